// File: doc/BRIEF.md
# Isolated Digital I/O Register Block

This block is a byte-wide register file that sits behind a simple synchronous host bus. It holds sixteen output latches, samples sixteen input lines through a synchronizer, and watches those inputs for changes in either direction. A change seen while interrupts are on raises a level interrupt toward the host. The host picks one of eight byte offsets with an address, then pulses a read strobe or a write strobe. Read data is combinational for the cycle of the read strobe.

Several control functions are set by the kind of access rather than by the data that is written. Reading the interrupt-control offset turns interrupts on, and writing it turns them off. Reading the filter offset turns the input-filter enable on, and writing it turns the enable off. Writing the low input offset, with any value, clears the pending change flags. The input filter is not modelled. Its enable is held in one bit and brought out on a pin.

A status byte reports which input group changed and whether the block is driving its interrupt. Software uses it to decide whether the shared interrupt line belongs to this block.

Top module: `iso_dio_regs`

## Requirements
- R1: After reset, `drv_out` is 0, `irq` is 0, `filt_en` is 0 and the status byte (offset 6) reads 0.
- R2: A write to offset 0 latches `bus_wdata` into `drv_out[7:0]`, and a write to offset 4 latches it into `drv_out[15:8]`. A read of offset 0 or offset 4 returns the latched byte.
- R3: A read of offset 1 returns the synchronized `pin_in[7:0]`, and a read of offset 5 returns the synchronized `pin_in[15:8]`. A pin change appears in read data no later than three clock edges after it.
- R4: A read of offset 2 enables interrupts. A write to offset 2 disables them, whatever the data value. Reads of offset 2 return 0.
- R5: A read of offset 3 sets `filt_en` to 1. A write to offset 3 clears it, whatever the data value. Reads of offset 3 return 0.
- R6: While interrupts are enabled, a rising or a falling change on any of `pin_in[7:0]` sets status bit 0, and a change on any of `pin_in[15:8]` sets status bit 1.
- R7: Input changes that occur while interrupts are disabled set no status bit and raise no interrupt, even after interrupts are enabled again.
- R8: `irq` equals (interrupts enabled) AND (status bit 0 OR status bit 1), and status bit 2 reads the same value as `irq`. Disabling interrupts drops `irq` but keeps bits 1:0. Re-enabling interrupts raises `irq` again.
- R9: A write of any value to offset 1 clears status bits 2:0 and drops `irq`.
- R10: Writes to offsets 5, 6 and 7 change nothing: `drv_out`, `irq`, `filt_en` and the status byte keep their values. A read of offset 6 has no side effect.
- R11: When `bus_rd` and `bus_wr` are both high in the same cycle, only the write takes effect. For example, both strobes at offset 2 disable interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register byte offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high, otherwise 0 |
| pin_in | input | 16 | Isolated input lines, asynchronous |
| drv_out | output | 16 | Output latch values |
| filt_en | output | 1 | Stored input-filter enable |
| irq | output | 1 | Level interrupt request |

## Verification
The embedded properties check the following on every cycle:
- the access-type rules: a read of the control offset leads to enable, a write leads to disable or filter-off, and a read of the filter offset leads to filter-on;
- the output latches stay frozen unless a write targets an output offset;
- no flag appears while interrupts are off;
- a clear with no coincident change drops `irq`;
- a disable keeps the pending flags.

Only the bench scenarios can show the other behaviours:
- that an edge on a particular pin lands in the correct group bit, in either direction, through the synchronizer latency;
- that pending flags survive a disable and re-assert `irq` after the next enable;
- that the data value written has no part in any of these controls.

// File: rtl/dio_pkg.sv
package dio_pkg;

    localparam int DIO_ADDR_W = 3;
    localparam int DIO_BYTE_W = 8;
    localparam int DIO_NGRP   = 2;
    localparam int DIO_NREG   = 1 << DIO_ADDR_W;
    localparam int DIO_PINS   = DIO_BYTE_W * DIO_NGRP;
    localparam int DIO_GRP_STRIDE = 4;

    typedef logic [DIO_ADDR_W-1:0] dio_addr_t;
    typedef logic [DIO_BYTE_W-1:0] dio_byte_t;

    localparam dio_addr_t OFS_IRQ_CTL = 3'd2;
    localparam dio_addr_t OFS_FILTER  = 3'd3;
    localparam dio_addr_t OFS_STATUS  = 3'd6;
    localparam dio_addr_t OFS_CLEAR   = 3'd1;

    typedef struct packed {
        logic [DIO_NREG-1:0] rd;
        logic [DIO_NREG-1:0] wr;
    } bus_acc_t;

    typedef struct packed {
        dio_byte_t [DIO_NGRP-1:0] outv;
        logic                     irq_en;
        logic                     filt;
        logic [DIO_NGRP-1:0]      pend;
    } dio_state_t;

    function automatic dio_addr_t out_ofs(input int g);
        return dio_addr_t'(g * DIO_GRP_STRIDE);
    endfunction

    function automatic dio_addr_t in_ofs(input int g);
        return dio_addr_t'(g * DIO_GRP_STRIDE + 1);
    endfunction

endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/dio_chg_detect.sv
module dio_chg_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur,
    output logic         chg
);

    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = cur;
        chg    = |(cur ^ prev_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/dio_bus_decode.sv
module dio_bus_decode
    import dio_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  dio_addr_t bus_addr,
    input  logic      bus_rd,
    input  logic      bus_wr,
    output bus_acc_t  acc
);

    always_comb begin
        acc = '0;
        for (int i = 0; i < DIO_NREG; i++) begin
            acc.wr[i] = bus_wr && (bus_addr == dio_addr_t'(i));
            acc.rd[i] = bus_rd && !bus_wr && (bus_addr == dio_addr_t'(i));
        end
    end

    // R11: a single access kind per cycle reaches the register file
    p_single_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc.rd, acc.wr}));

    p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> (acc.rd == '0));

endmodule

// File: rtl/iso_dio_regs.sv
module iso_dio_regs
    import dio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          bus_addr,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    input  logic [15:0]         pin_in,
    output logic [15:0]         drv_out,
    output logic                filt_en,
    output logic                irq
);

    bus_acc_t            acc;
    logic [DIO_PINS-1:0] pin_s;
    logic [DIO_NGRP-1:0] grp_chg;
    dio_state_t          st_d, st_q;
    dio_byte_t           status;

    dio_bus_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .acc      (acc)
    );

    dio_sync #(.W(DIO_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (pin_s)
    );

    for (genvar g = 0; g < DIO_NGRP; g++) begin : g_grp
        dio_chg_detect #(.W(DIO_BYTE_W)) u_chg (
            .clk   (clk),
            .rst_n (rst_n),
            .cur   (pin_s[g*DIO_BYTE_W +: DIO_BYTE_W]),
            .chg   (grp_chg[g])
        );
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        for (int g = 0; g < DIO_NGRP; g++) begin
            if (acc.wr[out_ofs(g)]) st_d.outv[g] = bus_wdata;
        end
        if (acc.rd[OFS_IRQ_CTL]) st_d.irq_en = 1'b1;
        if (acc.wr[OFS_IRQ_CTL]) st_d.irq_en = 1'b0;
        if (acc.rd[OFS_FILTER])  st_d.filt   = 1'b1;
        if (acc.wr[OFS_FILTER])  st_d.filt   = 1'b0;
        for (int g = 0; g < DIO_NGRP; g++) begin
            if (acc.wr[OFS_CLEAR])             st_d.pend[g] = 1'b0;
            if (st_q.irq_en && grp_chg[g])     st_d.pend[g] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // outputs and read path
    always_comb begin
        irq     = st_q.irq_en && (|st_q.pend);
        filt_en = st_q.filt;
        drv_out = st_q.outv;
        status  = '0;
        status[DIO_NGRP-1:0] = st_q.pend;
        status[DIO_NGRP]     = irq;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            for (int g = 0; g < DIO_NGRP; g++) begin
                if (bus_addr == out_ofs(g)) bus_rdata = st_q.outv[g];
                if (bus_addr == in_ofs(g))  bus_rdata = pin_s[g*DIO_BYTE_W +: DIO_BYTE_W];
            end
            if (bus_addr == OFS_STATUS) bus_rdata = status;
        end
    end

    // R4: access type controls the interrupt enable
    p_rd_enables_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == OFS_IRQ_CTL) |=> st_q.irq_en);

    p_wr_disables_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_IRQ_CTL) |=> !irq);

    // R5: access type controls the filter enable
    p_filt_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == OFS_FILTER) |=> filt_en);

    p_filt_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_FILTER) |=> !filt_en);

    // R7: no flag appears while interrupts are off
    p_quiet_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.irq_en && st_q.pend == '0) |=> (st_q.pend == '0));

    // R8: disable keeps the pending flags
    p_disable_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_IRQ_CTL && st_q.pend != '0) |=> (st_q.pend != '0));

    // R9: clear with no coincident change drops irq
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CLEAR && grp_chg == '0) |=> !irq);

    // R10: outputs move only on writes to an output offset
    p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == out_ofs(0) || bus_addr == out_ofs(1))) |=> $stable(drv_out));

endmodule

// File: tb/iso_dio_regs_test.sv
module iso_dio_regs_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] drv_out;
    logic        filt_en;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    iso_dio_regs uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .drv_out   (drv_out),
        .filt_en   (filt_en),
        .irq       (irq)
    );

    // monitor: compares read data against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && bus_rd) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected read: got %02h expected none", bus_rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: read %02h expected %02h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic access(input bit rd, input bit wr, input logic [2:0] a,
                          input logic [7:0] d, input logic [7:0] e, input string t);
        @(posedge clk); #2;
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = d;
        if (rd) begin exp_q.push_back(e); tag_q.push_back(t); end
        @(posedge clk); #2;
        bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
        access(1'b1, 1'b0, a, 8'h00, e, t);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        access(1'b0, 1'b1, a, d, 8'h00, "");
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
        @(negedge clk);
        n_cmp++;
        if (act !== e) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", t, act, e);
        end
    endtask

    task automatic pins(input logic [15:0] v);
        @(posedge clk); #2;
        pin_in = v;
        repeat (5) @(posedge clk);
        #2;
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state
        chk(drv_out, 0, "R1 drv_out");
        chk(irq, 0, "R1 irq");
        chk(filt_en, 0, "R1 filt_en");
        rd(3'd6, 8'h00, "R1 status");

        // R2 output latches and readback
        wr(3'd0, 8'hA5);
        wr(3'd4, 8'h3C);
        chk(drv_out, 16'h3CA5, "R2 drv_out");
        rd(3'd0, 8'hA5, "R2 low readback");
        rd(3'd4, 8'h3C, "R2 high readback");

        // R3 inputs; R7 changes while disabled are not recorded
        pins(16'h8142);
        rd(3'd1, 8'h42, "R3 inputs low");
        rd(3'd5, 8'h81, "R3 inputs high");
        rd(3'd6, 8'h00, "R7 no flag while disabled");

        // R4 enable by read, R6 rising edge on low group
        rd(3'd2, 8'h00, "R4 enable read data");
        chk(irq, 0, "R4 nothing pending yet");
        pins(16'h814A);
        chk(irq, 1, "R6 irq on rising low");
        rd(3'd6, 8'h05, "R6 low group flag");

        // R9 clear with data 00
        wr(3'd1, 8'h00);
        chk(irq, 0, "R9 irq cleared");
        rd(3'd6, 8'h00, "R9 status cleared");

        // R6 falling edge, clear with data FF
        pins(16'h8142);
        rd(3'd6, 8'h05, "R6 falling low");
        wr(3'd1, 8'hFF);
        rd(3'd6, 8'h00, "R9 clear data FF");

        // R6 high group
        pins(16'h0142);
        rd(3'd6, 8'h06, "R6 high group flag");

        // R8 disable keeps pending, re-enable raises irq
        wr(3'd2, 8'hFF);
        chk(irq, 0, "R4 write FF disables");
        rd(3'd6, 8'h02, "R8 pending kept when disabled");
        rd(3'd2, 8'h00, "R8 re-enable");
        chk(irq, 1, "R8 irq back");
        wr(3'd1, 8'h5A);

        // R7 changes while disabled (write 00 disables too)
        wr(3'd2, 8'h00);
        pins(16'h0F0F);
        rd(3'd6, 8'h00, "R7 disabled changes dropped");
        rd(3'd2, 8'h00, "R7 enable afterwards");
        chk(irq, 0, "R7 no irq after enable");

        // R5 filter control by access type
        rd(3'd3, 8'h00, "R5 filter read data");
        chk(filt_en, 1, "R5 filter on by read");
        wr(3'd3, 8'hFF);
        chk(filt_en, 0, "R5 filter off by write FF");
        rd(3'd3, 8'h00, "R5 filter read again");
        wr(3'd3, 8'h01);
        chk(filt_en, 0, "R5 filter off by write 01");

        // R10 read-only offsets ignore writes
        pins(16'h0F1F);
        rd(3'd6, 8'h05, "R10 setup pending");
        wr(3'd5, 8'hFF);
        wr(3'd6, 8'hFF);
        wr(3'd7, 8'hFF);
        chk(drv_out, 16'h3CA5, "R10 drv_out unchanged");
        chk(irq, 1, "R10 irq unchanged");
        chk(filt_en, 0, "R10 filt_en unchanged");
        rd(3'd6, 8'h05, "R10 status unchanged");
        rd(3'd6, 8'h05, "R10 status read no side effect");

        // R11 both strobes: write wins
        access(1'b1, 1'b1, 3'd2, 8'h77, 8'h00, "R11 both strobes read data");
        chk(irq, 0, "R11 write wins disables");
        rd(3'd6, 8'h01, "R11 pending kept");

        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard: got %0d left expected 0", exp_q.size());
        end
        done = 1;
        finish_run();
    end

endmodule